// File: doc/BRIEF.md
# Banked Register Context Restore Controller

This block keeps a small stack of saved register sets so that an interrupt handler can get back the interrupted context quickly. Each saved set has twenty 32-bit slots. Slots 0 to 14 hold the general registers, and the other slots hold the multiply-accumulate halves, the procedure return register and the global base register. Interrupt entry logic, which lies outside this block, fills a set and signals this with a pulse that raises the count of occupied sets. The CPU sends decoded 16-bit opcodes to the controller. Two of these opcodes move one word between R0 and any slot of any set. A third opcode restores a context.

A restore normally takes the newest set off the stack and writes its nineteen live-register values back through a single register-file write port, one value per cycle. When the CPU's overflow flag is set, the entry logic has already put the context on the memory stack. In that case the controller pops a nineteen-word frame upward from the stack pointer through a valid/ready read port. It then writes the advanced stack pointer back. A restore that finds no saved set raises an illegal-instruction exception. A restore issued in a branch delay slot raises a slot exception.

Top module: `bank_ctx_ctrl`

## Requirements
- R1: After reset, busy, done, rf_we, mem_req_valid, exc_illegal and exc_slot are low, and bank_num is 0.
- R2: The store opcode (bits [15:12]=0100 and [7:0]=11100001) writes r0_val into set addr_reg[15:7] at slot addr_reg[6:2]. done is high in the cycle that follows acceptance.
- R3: The load opcode (bits [15:12]=0100 and [7:0]=11100101) returns the addressed slot in the cycle after acceptance. In that cycle rf_we=1, rf_sel=0 (R0), rf_wdata holds the slot value and done=1.
- R4: For single-word access, a slot field above 19 addresses slot 19.
- R5: The set field addr_reg[15:7] is taken modulo NBANK.
- R6: An entry_push pulse in an idle cycle with no accepted command increments bank_num. bank_num saturates at NBANK.
- R7: A restore (opcode 16'h005B) with bank_ovf low and bank_num nonzero first decrements bank_num. It then writes, one value per cycle and in this order, slots 0..14 to R0..R14, slot 15 to MACH, slot 17 to PR, slot 18 to GBR and slot 19 to MACL. The set used is the one at index bank_num after the decrement. done rises together with the last write.
- R8: The rf_sel encoding is 0..14 = R0..R14, 15 = R15, 16 = PR, 17 = GBR, 18 = MACH and 19 = MACL.
- R9: A restore with bank_ovf high reads 19 words, starting at sp_val and moving up 4 bytes per accepted read (mem_req_valid and mem_ready both high). The words go to R0..R14, PR, GBR, MACH and MACL in that order. The controller then writes R15 = sp_val+76 with done. bank_num does not change.
- R10: A restore with bank_ovf low and bank_num 0 pulses exc_illegal in the following cycle and has no other effect.
- R11: A restore with cmd_in_delay_slot high pulses exc_slot in the following cycle and changes nothing, whatever the value of bank_ovf.
- R12: Slot 16 can be stored and loaded, and a restore never writes it to any register.
- R13: Commands presented while busy are ignored. Opcodes other than the three above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Opcode presented |
| cmd_op | input | 16 | Opcode |
| cmd_in_delay_slot | input | 1 | Opcode sits in a branch delay slot |
| bank_ovf | input | 1 | Overflow flag: restore from memory stack |
| addr_reg | input | 32 | Value of the addressing register for single-word access |
| r0_val | input | 32 | Value of R0 |
| sp_val | input | 32 | Value of R15 |
| entry_push | input | 1 | Interrupt entry has filled one more set |
| mem_ready | input | 1 | Read accepted, data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Restore sequence running |
| done | output | 1 | Operation completed |
| exc_illegal | output | 1 | Underflow exception pulse |
| exc_slot | output | 1 | Delay-slot exception pulse |
| bank_num | output | clog2(NBANK+1) | Number of occupied sets |
| rf_we | output | 1 | Register write strobe |
| rf_sel | output | 5 | Register written (R8 encoding) |
| rf_wdata | output | 32 | Register write data |
| mem_req_valid | output | 1 | Read request |
| mem_req_addr | output | 32 | Read address |

## Verification
Assertions check on every cycle that exceptions appear only while idle and leave bank_num unchanged, that the read address moves up by exactly four after each accepted read, and that a banked restore starts by decrementing bank_num. They also check that register writes outside a running sequence always carry done. Only the bench scenarios can show that the write order, the slot map, the clamp, the modulo wrap and the final stack pointer are correct, and that a command held during a restore leaves storage unchanged. These properties depend on data values that have to be compared against an independent model.

// File: rtl/bank_ctx_ctrl.sv
module bank_ctx_ctrl #(
  parameter int NBANK = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [15:0]                  cmd_op,
  input  logic                         cmd_in_delay_slot,
  input  logic                         bank_ovf,
  input  logic [31:0]                  addr_reg,
  input  logic [31:0]                  r0_val,
  input  logic [31:0]                  sp_val,
  input  logic                         entry_push,
  input  logic                         mem_ready,
  input  logic [31:0]                  mem_rdata,
  output logic                         busy,
  output logic                         done,
  output logic                         exc_illegal,
  output logic                         exc_slot,
  output logic [$clog2(NBANK+1)-1:0]   bank_num,
  output logic                         rf_we,
  output logic [4:0]                   rf_sel,
  output logic [31:0]                  rf_wdata,
  output logic                         mem_req_valid,
  output logic [31:0]                  mem_req_addr
);
  localparam int NSLOT = 20;
  localparam int BNW   = $clog2(NBANK + 1);
  localparam int BIW   = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int IW    = $clog2(NBANK * NSLOT);
  localparam logic [4:0] LAST = 5'd18;

  typedef enum logic [1:0] {S_IDLE, S_BANK, S_MEM, S_SPWB} st_t;
  st_t st;
  logic [4:0]     cnt;
  logic [31:0]    ptr;
  logic [BIW-1:0] cur;
  logic [31:0]    slots_q [NBANK*NSLOT];

  wire is_rest = cmd_op == 16'h005B;
  wire is_ld   = cmd_op[15:12] == 4'h4 && cmd_op[7:0] == 8'hE5;
  wire is_st   = cmd_op[15:12] == 4'h4 && cmd_op[7:0] == 8'hE1;
  wire accept  = cmd_valid && st == S_IDLE;

  wire [4:0]    slot   = (addr_reg[6:2] > 5'd19) ? 5'd19 : addr_reg[6:2];
  wire [8:0]    bwrap  = addr_reg[15:7] % 9'(NBANK);
  wire [IW-1:0] acc_ix = IW'(bwrap) * IW'(NSLOT) + IW'(slot);

  wire [4:0] bslot = (cnt < 5'd15) ? cnt : (cnt == 5'd15) ? 5'd15 : cnt + 5'd1;
  wire [4:0] bsel  = (cnt == 5'd15) ? 5'd18 : (cnt == 5'd18) ? 5'd19 : cnt;
  wire [4:0] msel  = (cnt < 5'd15) ? cnt : cnt + 5'd1;
  wire [IW-1:0] rst_ix = IW'(cur) * IW'(NSLOT) + IW'(bslot);

  logic unused_bits;
  assign unused_bits = ^{addr_reg[31:16], addr_reg[1:0], cmd_op[11:8]};

  assign busy          = st != S_IDLE;
  assign mem_req_valid = st == S_MEM;
  assign mem_req_addr  = ptr;

  always_ff @(posedge clk) begin
    if (accept && is_st) slots_q[acc_ix] <= r0_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      ptr <= '0;
      cur <= '0;
      bank_num <= '0;
      rf_we <= 1'b0;
      rf_sel <= '0;
      rf_wdata <= '0;
      done <= 1'b0;
      exc_illegal <= 1'b0;
      exc_slot <= 1'b0;
    end else begin
      rf_we <= 1'b0;
      done <= 1'b0;
      exc_illegal <= 1'b0;
      exc_slot <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            if (is_ld) begin
              rf_we <= 1'b1;
              rf_sel <= 5'd0;
              rf_wdata <= slots_q[acc_ix];
              done <= 1'b1;
            end else if (is_st) begin
              done <= 1'b1;
            end else if (is_rest) begin
              if (cmd_in_delay_slot) exc_slot <= 1'b1;
              else if (bank_ovf) begin
                st <= S_MEM;
                cnt <= '0;
                ptr <= sp_val;
              end else if (bank_num == '0) exc_illegal <= 1'b1;
              else begin
                bank_num <= bank_num - 1'b1;
                cur <= BIW'(bank_num - 1'b1);
                cnt <= '0;
                st <= S_BANK;
              end
            end
          end else if (entry_push && bank_num < BNW'(NBANK)) begin
            bank_num <= bank_num + 1'b1;
          end
        end
        S_BANK: begin
          rf_we <= 1'b1;
          rf_sel <= bsel;
          rf_wdata <= slots_q[rst_ix];
          cnt <= cnt + 5'd1;
          if (cnt == LAST) begin
            st <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_MEM: begin
          if (mem_ready) begin
            rf_we <= 1'b1;
            rf_sel <= msel;
            rf_wdata <= mem_rdata;
            ptr <= ptr + 32'd4;
            cnt <= cnt + 5'd1;
            if (cnt == LAST) st <= S_SPWB;
          end
        end
        default: begin
          rf_we <= 1'b1;
          rf_sel <= 5'd15;
          rf_wdata <= ptr;
          done <= 1'b1;
          st <= S_IDLE;
        end
      endcase
    end
  end

  p_underflow_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_illegal |-> (!busy && bank_num == '0 && !rf_we));

  p_slot_exc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_slot |-> (!busy && !rf_we && $stable(bank_num)));

  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_ready) |=> (!mem_req_valid || mem_req_addr == $past(mem_req_addr) + 32'd4));

  p_bank_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !mem_req_valid) |-> bank_num == $past(bank_num) - 1'b1);

  p_idle_write_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !busy) |-> done);

  p_bank_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_num <= BNW'(NBANK));
endmodule

// File: tb/bank_ctx_ctrl_test.sv
module bank_ctx_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_op = '0;
  logic cmd_in_delay_slot = 1'b0;
  logic bank_ovf = 1'b0;
  logic [31:0] addr_reg = '0, r0_val = '0, sp_val = '0;
  logic entry_push = 1'b0;
  logic mem_ready = 1'b0;
  logic [31:0] mem_rdata;
  logic busy, done, exc_illegal, exc_slot, rf_we, mem_req_valid;
  logic [2:0] bank_num;
  logic [4:0] rf_sel;
  logic [31:0] rf_wdata, mem_req_addr;

  localparam logic [15:0] OP_REST = 16'h005B;
  localparam logic [15:0] OP_LD   = 16'h43E5;
  localparam logic [15:0] OP_ST   = 16'h47E1;

  int tests = 0, fails = 0, rcyc = 0;
  logic [31:0] model [4][20];
  int nw;
  logic [4:0]  w_sel [32];
  logic [31:0] w_dat [32];
  logic        w_done;

  bank_ctx_ctrl #(.NBANK(4)) uut (.*);

  always #4 clk = ~clk;
  assign mem_rdata = mem_req_addr ^ 32'hA5A5_0000;
  always @(negedge clk) begin
    rcyc = rcyc + 1;
    mem_ready = (rcyc % 3) != 0;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] adr(input int b, input int s);
    return (32'(b) << 7) | (32'(s) << 2);
  endfunction

  task automatic issue(input logic [15:0] op, input logic [31:0] a, input logic [31:0] d, input bit ds);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; addr_reg = a; r0_val = d; cmd_in_delay_slot = ds;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_in_delay_slot = 1'b0;
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); entry_push = 1'b1;
      @(negedge clk); entry_push = 1'b0;
    end
  endtask

  task automatic collect();
    nw = 0; w_done = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (rf_we && nw < 32) begin w_sel[nw] = rf_sel; w_dat[nw] = rf_wdata; nw++; end
      if (done) begin w_done = rf_we; break; end
    end
  endtask

  task automatic do_load(input int b, input int s, input logic [31:0] exp, input string req);
    issue(OP_LD, adr(b, s), 32'h0, 1'b0);
    check(rf_we && done && rf_sel == 5'd0, req, {rf_we, done, 25'd0, rf_sel}, {2'b11, 30'd0});
    check(rf_wdata == exp, req, rf_wdata, exp);
  endtask

  task automatic t_reset();
    check(!busy && !done && !rf_we && !mem_req_valid && !exc_illegal && !exc_slot, "R1",
          {busy, done, rf_we, mem_req_valid, exc_illegal, exc_slot}, 32'h0);
    check(bank_num == 3'd0, "R1", 32'(bank_num), 32'h0);
  endtask

  task automatic t_store_load();
    for (int s = 0; s < 20; s++) begin
      model[1][s] = 32'hB100_0000 + 32'(s * 17);
      issue(OP_ST, adr(1, s), model[1][s], 1'b0);
      if (s == 0) check(done && !rf_we, "R2", {done, rf_we}, 32'h2);
    end
    do_load(1, 7, model[1][7], "R3");
    do_load(1, 16, model[1][16], "R12");
    do_load(1, 0, model[1][0], "R2");
  endtask

  task automatic t_clamp();
    model[2][19] = 32'h0000_C1A4;
    issue(OP_ST, adr(2, 27), model[2][19], 1'b0);
    do_load(2, 19, model[2][19], "R4");
    do_load(2, 31, model[2][19], "R4");
  endtask

  task automatic t_wrap();
    model[2][5] = 32'h5A5A_0005;
    issue(OP_ST, adr(6, 5), model[2][5], 1'b0);
    do_load(2, 5, model[2][5], "R5");
    do_load(10, 5, model[2][5], "R5");
  endtask

  task automatic t_underflow();
    issue(OP_REST, 32'h0, 32'h0, 1'b0);
    check(exc_illegal && !busy && !rf_we && !done, "R10", {exc_illegal, busy, rf_we, done}, 32'h8);
    check(bank_num == 3'd0, "R10", 32'(bank_num), 32'h0);
  endtask

  task automatic t_delay();
    bank_ovf = 1'b1;
    issue(OP_REST, 32'h0, 32'h0, 1'b1);
    check(exc_slot && !busy && !rf_we, "R11", {exc_slot, busy, rf_we}, 32'h4);
    bank_ovf = 1'b0;
    issue(OP_REST, 32'h0, 32'h0, 1'b1);
    check(exc_slot && !busy, "R11", {exc_slot, busy}, 32'h2);
    check(bank_num == 3'd2, "R11", 32'(bank_num), 32'h2);
  endtask

  task automatic t_banked();
    int slot_of [19];
    int sel_of  [19];
    bit hit16;
    for (int i = 0; i < 15; i++) begin slot_of[i] = i; sel_of[i] = i; end
    slot_of[15] = 15; sel_of[15] = 18;
    slot_of[16] = 17; sel_of[16] = 16;
    slot_of[17] = 18; sel_of[17] = 17;
    slot_of[18] = 19; sel_of[18] = 19;
    issue(OP_REST, 32'h0, 32'h0, 1'b0);
    check(busy && bank_num == 3'd1, "R7", {busy, 28'd0, bank_num}, {1'b1, 28'd0, 3'd1});
    cmd_valid = 1'b1; cmd_op = OP_ST; addr_reg = adr(1, 0); r0_val = 32'hDEAD_BEEF;
    collect();
    cmd_valid = 1'b0;
    check(nw == 19, "R7", 32'(nw), 32'd19);
    check(w_done, "R7", 32'(w_done), 32'h1);
    hit16 = 1'b0;
    for (int i = 0; i < 19 && i < nw; i++) begin
      check(w_sel[i] == 5'(sel_of[i]), "R8", 32'(w_sel[i]), 32'(sel_of[i]));
      check(w_dat[i] == model[1][slot_of[i]], "R7", w_dat[i], model[1][slot_of[i]]);
      if (w_dat[i] == model[1][16]) hit16 = 1'b1;
    end
    check(!hit16, "R12", 32'(hit16), 32'h0);
    do_load(1, 0, model[1][0], "R13");
  endtask

  task automatic t_mem();
    bank_ovf = 1'b1; sp_val = 32'h0000_0200;
    issue(OP_REST, 32'h0, 32'h0, 1'b0);
    collect();
    bank_ovf = 1'b0;
    check(nw == 20, "R9", 32'(nw), 32'd20);
    check(w_done, "R9", 32'(w_done), 32'h1);
    for (int i = 0; i < 19 && i < nw; i++) begin
      check(w_sel[i] == ((i < 15) ? 5'(i) : 5'(i + 1)), "R9", 32'(w_sel[i]), (i < 15) ? 32'(i) : 32'(i + 1));
      check(w_dat[i] == ((32'h200 + 32'(4 * i)) ^ 32'hA5A5_0000), "R9", w_dat[i], (32'h200 + 32'(4 * i)) ^ 32'hA5A5_0000);
    end
    if (nw == 20) begin
      check(w_sel[19] == 5'd15 && w_dat[19] == 32'h24C, "R9", w_dat[19], 32'h24C);
    end
    check(bank_num == 3'd1, "R9", 32'(bank_num), 32'h1);
  endtask

  task automatic t_push_sat();
    push(6);
    check(bank_num == 3'd4, "R6", 32'(bank_num), 32'h4);
  endtask

  task automatic t_unknown();
    issue(16'h0009, adr(1, 3), 32'h1234, 1'b0);
    check(!done && !rf_we && !busy && !exc_illegal, "R13", {done, rf_we, busy, exc_illegal}, 32'h0);
    do_load(1, 3, model[1][3], "R13");
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store_load();
    t_clamp();
    t_wrap();
    t_underflow();
    push(2);
    check(bank_num == 3'd2, "R6", 32'(bank_num), 32'h2);
    t_delay();
    t_banked();
    t_mem();
    t_unknown();
    t_push_sat();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule